// File: doc/BRIEF.md
# Down-Spread Modulation Profile Generator

The block produces a periodic, always non-positive frequency-offset word that a fractional-N feedback divider adds to its nominal ratio, so that a synthesized processor clock sweeps downward from its nominal frequency and back. The sweep is a symmetric triangle. It starts at zero, falls to the selected peak depth at mid-period and climbs back to zero by the end of the period. A one-cycle strobe marks the first cycle of every period.

The depth comes from a sparse 3-bit select code. Four of the code values pick a depth and the other four mean no spread. The block samples the code only on entry to a period, while the offset is zero, so a new setting never causes a frequency step. When the enable input is low, the generator is parked: the phase is cleared, the offset is held at zero and no strobe is issued. When the enable returns, a fresh period begins.

The offset is a signed fraction of the nominal divider value, with 2^(OFS_W-1) standing for 1.0. The period length is set in reference cycles. The default of 771 gives about 35 kHz from a 27 MHz reference, inside the allowed 30 to 40 kHz modulation-rate window.

Top module: `ssc_profile_gen`

## Requirements
- R1: `offset_o`, read as a signed value, is never greater than zero.
- R2: The select code maps to a peak depth of floor(2^(OFS_W-1)*m/1000), with m = 5 for code 001, 10 for 010, 20 for 100 and 30 for 110. With OFS_W=16 these depths are 163, 327, 655 and 983. The offset reaches minus the peak at phase H = PERIOD_CYC/2 (integer division).
- R3: Codes 000, 011, 101 and 111 hold `offset_o` at zero for the whole period.
- R4: While enabled, a period lasts exactly PERIOD_CYC cycles. `period_start_o` is high for one cycle at phase 0, and in that cycle `offset_o` is zero.
- R5: At phase p of a period, `offset_o` equals -floor(peak*t/H). Here t = p for p <= H, and t = PERIOD_CYC - p otherwise.
- R6: A select code is sampled only on entry to phase 0. A change made during a period has no effect until the next period.
- R7: With `spread_en_i` low at a clock edge, `offset_o` is zero and `period_start_o` is low after that edge. The first edge that samples the enable high starts a period, so the strobe appears after that edge.
- R8: After reset, `offset_o` is zero and `period_start_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spread_sel_i | input | 3 | Spread depth select code |
| spread_en_i | input | 1 | Enable for the spread clock; low parks the generator |
| offset_o | output | OFS_W | Signed frequency offset, a fraction of nominal |
| period_start_o | output | 1 | One-cycle strobe at the start of each modulation period |

## Verification
The assertions take for granted that the enable and select inputs are synchronous to the reference clock and settled at each rising edge. The per-cycle step bound and the period counter are checked only across edges where the enable was high; a deliberate disable may jump the offset straight to zero. The bench keeps to this by driving every input on the falling edge. It drops the enable only mid-period and raises it again only after several parked cycles, so the period counter is never checked across a disable.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [1:0] {
    CMD_CLR  = 2'd0,
    CMD_UP   = 2'd1,
    CMD_DN   = 2'd2,
    CMD_HOLD = 2'd3
  } ramp_cmd_e;

  // depth in thousandths of nominal; zero means no spread
  function automatic int unsigned depth_permille(input logic [2:0] code);
    case (code)
      3'b001:  return 5;
      3'b010:  return 10;
      3'b100:  return 20;
      3'b110:  return 30;
      default: return 0;
    endcase
  endfunction

  function automatic longint unsigned peak_of(input logic [2:0] code, input int ofs_w);
    longint unsigned one;
    one = longint'(1) << (ofs_w - 1);
    return (one * longint'(depth_permille(code))) / 1000;
  endfunction

endpackage

// File: rtl/ssc_phase_ctr.sv
module ssc_phase_ctr
  import ssc_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 771,
  localparam int unsigned HALF = PERIOD_CYC / 2,
  localparam int unsigned PW = $clog2(PERIOD_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [PW-1:0] phase_o,
  output logic          run_o,
  output ramp_cmd_e     cmd_o
);

  localparam logic [PW-1:0] LAST   = PW'(PERIOD_CYC - 1);
  localparam logic [PW-1:0] HALF_P = PW'(HALF);
  localparam bit            ODD    = (PERIOD_CYC % 2) == 1;

  logic [PW-1:0] phase_q, phase_d;
  logic          run_q;

  always_comb begin
    if (!en_i || !run_q)    phase_d = '0;
    else if (phase_q == LAST) phase_d = '0;
    else                    phase_d = phase_q + 1'b1;
  end

  always_comb begin
    if (!en_i || !run_q || phase_d == '0)  cmd_o = CMD_CLR;
    else if (phase_d <= HALF_P)            cmd_o = CMD_UP;
    else if (ODD && phase_d == HALF_P + 1'b1) cmd_o = CMD_HOLD;
    else                                   cmd_o = CMD_DN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      run_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      run_q   <= en_i;
    end
  end

  assign phase_o = phase_q;
  assign run_o   = run_q;

endmodule

// File: rtl/ssc_step_sel.sv
module ssc_step_sel
  import ssc_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 771,
  parameter int unsigned OFS_W      = 16,
  localparam int unsigned HALF = PERIOD_CYC / 2,
  localparam int unsigned RW   = $clog2(HALF + 1) + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [2:0]              code_i,
  output logic [OFS_W-1:0]        qstep_o,
  output logic signed [RW-1:0]    rstep_o
);

  localparam logic [2:0] CODE_RST = 3'b010;

  logic [2:0]           code_q;
  logic [OFS_W-1:0]     qtab [8];
  logic signed [RW-1:0] rtab [8];

  // per-code whole and fractional step of peak/HALF
  for (genvar c = 0; c < 8; c++) begin : g_tab
    localparam longint unsigned PK = peak_of(3'(c), OFS_W);
    assign qtab[c] = OFS_W'(PK / longint'(HALF));
    assign rtab[c] = RW'(PK % longint'(HALF));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= CODE_RST;
    else if (load_i) code_q <= code_i;
  end

  assign qstep_o = qtab[code_q];
  assign rstep_o = rtab[code_q];

endmodule

// File: rtl/ssc_ramp.sv
module ssc_ramp
  import ssc_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 771,
  parameter int unsigned OFS_W      = 16,
  localparam int unsigned HALF = PERIOD_CYC / 2,
  localparam int unsigned RW   = $clog2(HALF + 1) + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  ramp_cmd_e            cmd_i,
  input  logic [OFS_W-1:0]     qstep_i,
  input  logic signed [RW-1:0] rstep_i,
  output logic [OFS_W-1:0]     mag_o
);

  localparam logic signed [RW-1:0] HALF_S = RW'(HALF);

  // mag*HALF + rem tracks peak*t exactly
  logic [OFS_W-1:0]     mag_q, mag_d;
  logic signed [RW-1:0] rem_q, rem_d;
  logic signed [RW-1:0] rem_up, rem_dn;

  assign rem_up = rem_q + rstep_i;
  assign rem_dn = rem_q - rstep_i;

  always_comb begin
    mag_d = mag_q;
    rem_d = rem_q;
    unique case (cmd_i)
      CMD_CLR: begin
        mag_d = '0;
        rem_d = '0;
      end
      CMD_UP: begin
        if (rem_up >= HALF_S) begin
          rem_d = rem_up - HALF_S;
          mag_d = mag_q + qstep_i + 1'b1;
        end else begin
          rem_d = rem_up;
          mag_d = mag_q + qstep_i;
        end
      end
      CMD_DN: begin
        if (rem_dn < 0) begin
          rem_d = rem_dn + HALF_S;
          mag_d = mag_q - qstep_i - 1'b1;
        end else begin
          rem_d = rem_dn;
          mag_d = mag_q - qstep_i;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q <= '0;
      rem_q <= '0;
    end else begin
      mag_q <= mag_d;
      rem_q <= rem_d;
    end
  end

  assign mag_o = mag_q;

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 771,
  parameter int unsigned OFS_W      = 16,
  localparam int unsigned HALF = PERIOD_CYC / 2,
  localparam int unsigned PW   = $clog2(PERIOD_CYC),
  localparam int unsigned RW   = $clog2(HALF + 1) + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2:0]              spread_sel_i,
  input  logic                    spread_en_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    period_start_o
);

  logic [PW-1:0]        phase;
  logic                 run;
  ramp_cmd_e            cmd;
  logic [OFS_W-1:0]     qstep;
  logic signed [RW-1:0] rstep;
  logic [OFS_W-1:0]     mag;

  ssc_phase_ctr #(.PERIOD_CYC(PERIOD_CYC)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (spread_en_i),
    .phase_o (phase),
    .run_o   (run),
    .cmd_o   (cmd)
  );

  // code is taken only while the offset is returning to zero
  ssc_step_sel #(.PERIOD_CYC(PERIOD_CYC), .OFS_W(OFS_W)) u_step (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cmd == CMD_CLR),
    .code_i  (spread_sel_i),
    .qstep_o (qstep),
    .rstep_o (rstep)
  );

  ssc_ramp #(.PERIOD_CYC(PERIOD_CYC), .OFS_W(OFS_W)) u_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .qstep_i (qstep),
    .rstep_i (rstep),
    .mag_o   (mag)
  );

  assign offset_o       = -$signed(mag);
  assign period_start_o = run && (phase == '0);

endmodule

// File: rtl/ssc_profile_gen_chk.sv
module ssc_profile_gen_chk
  import ssc_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 771,
  parameter int unsigned OFS_W      = 16,
  localparam int unsigned HALF = PERIOD_CYC / 2,
  localparam int unsigned CW   = $clog2(PERIOD_CYC) + 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    spread_en_i,
  input logic signed [OFS_W-1:0] offset_o,
  input logic                    period_start_o
);

  localparam longint MAX_PEAK = longint'(peak_of(3'b110, OFS_W));
  localparam longint MAX_STEP = MAX_PEAK / longint'(HALF) + 1;

  logic [CW-1:0] cnt_q;
  logic          valid_q;
  logic          past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      valid_q   <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      past_ok_q <= 1'b1;
      if (period_start_o) cnt_q <= '0;
      else if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (!spread_en_i)        valid_q <= 1'b0;
      else if (period_start_o) valid_q <= 1'b1;
    end
  end

  AST_NOT_POSITIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset_o <= 0); // R1

  AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    longint'(offset_o) >= -MAX_PEAK); // R2

  AST_START_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |-> offset_o == 0); // R4

  AST_PERIOD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start_o && valid_q) |-> cnt_q == CW'(PERIOD_CYC - 1)); // R4

  AST_STEP_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(spread_en_i)) |->
      (longint'(offset_o) - longint'($past(offset_o)) <= MAX_STEP &&
       longint'($past(offset_o)) - longint'(offset_o) <= MAX_STEP)); // R5

  AST_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spread_en_i |=> (offset_o == 0 && !period_start_o)); // R7

endmodule

bind ssc_profile_gen ssc_profile_gen_chk #(.PERIOD_CYC(PERIOD_CYC), .OFS_W(OFS_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .spread_en_i    (spread_en_i),
  .offset_o       (offset_o),
  .period_start_o (period_start_o)
);

// File: tb/ssc_profile_gen_test.sv
module ssc_profile_gen_test;

  localparam int P  = 771;
  localparam int W  = 16;
  localparam int H  = P / 2;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [2:0]          spread_sel_i = 3'b010;
  logic                spread_en_i = 1'b0;
  logic signed [W-1:0] offset_o;
  logic                period_start_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ssc_profile_gen #(.PERIOD_CYC(P), .OFS_W(W)) uut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .spread_sel_i   (spread_sel_i),
    .spread_en_i    (spread_en_i),
    .offset_o       (offset_o),
    .period_start_o (period_start_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic longint peak(input logic [2:0] c);
    case (c)
      3'b001:  return 163;
      3'b010:  return 327;
      3'b100:  return 655;
      3'b110:  return 983;
      default: return 0;
    endcase
  endfunction

  function automatic longint expect_ofs(input logic [2:0] c, input int p);
    longint t;
    t = (p <= H) ? p : P - p;
    return -((peak(c) * t) / H);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // starts on a negedge where the strobe is due; ends on the next one
  task automatic check_period(input logic [2:0] c, input int chg_at, input logic [2:0] nc,
                              input string req);
    int bad = 0;
    longint mn = 0;
    longint first_act = 0, first_exp = 0;
    for (int p = 0; p < P; p++) begin
      if (longint'(offset_o) != expect_ofs(c, p) || period_start_o != (p == 0)) begin
        if (bad == 0) begin
          first_act = longint'(offset_o);
          first_exp = expect_ofs(c, p);
        end
        bad++;
      end
      if (longint'(offset_o) < mn) mn = longint'(offset_o);
      if (p == chg_at) spread_sel_i = nc;
      @(negedge clk_i);
    end
    check(bad == 0, {req, " R5 R4 profile"}, first_act, first_exp);
    check(mn == -peak(c), {req, " R2 R3 peak"}, mn, -peak(c));
    check(period_start_o == 1'b1, "R4 next strobe", longint'(period_start_o), 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    check(offset_o == 0, "R8 reset offset", longint'(offset_o), 0);
    check(period_start_o == 0, "R8 reset strobe", longint'(period_start_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(offset_o == 0 && period_start_o == 0, "R7 parked after reset",
          longint'(offset_o), 0);
  endtask

  task automatic t_enable();
    spread_en_i = 1'b1;
    @(negedge clk_i);
    check(period_start_o == 1, "R7 start on enable", longint'(period_start_o), 1);
  endtask

  task automatic t_codes();
    // mid-period changes must wait for the boundary (R6)
    check_period(3'b010, 200, 3'b001, "R6 code 010");
    check_period(3'b001, 5,   3'b100, "R6 code 001");
    check_period(3'b100, 700, 3'b110, "R6 code 100");
    check_period(3'b110, 50,  3'b011, "code 110");
    check_period(3'b011, 10,  3'b111, "R3 code 011");
    check_period(3'b111, 10,  3'b000, "R3 code 111");
    check_period(3'b000, 10,  3'b101, "R3 code 000");
    check_period(3'b101, 10,  3'b110, "R3 code 101");
  endtask

  task automatic t_disable();
    bit bad = 0;
    repeat (300) @(negedge clk_i);
    check(offset_o < 0, "R1 mid-period negative", longint'(offset_o), -1);
    spread_en_i = 1'b0;
    spread_sel_i = 3'b100;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (offset_o != 0 || period_start_o) bad = 1;
    end
    check(!bad, "R7 parked holds zero", longint'(offset_o), 0);
    spread_en_i = 1'b1;
    @(negedge clk_i);
    check(period_start_o == 1, "R7 restart strobe", longint'(period_start_o), 1);
    check_period(3'b100, -1, 3'b100, "R7 restart code 100");
  endtask

  initial begin
    t_reset();
    t_enable();
    t_codes();
    t_disable();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule